// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block computes data-memory addresses for one memory bank. It holds a pointer register and a window-length register. The pointer is presented directly as the memory address. In a cycle with an access, the pointer is changed at the closing clock edge by a signed step. That step may be a post-increment, a post-decrement or an arbitrary offset.

In circular mode the pointer stays inside a window. The window starts at the pointer with its low ceil(log2(len)) bits cleared and is `len` words long. `len` does not need to be a power of two. This lets a sample delay line rotate in place instead of moving its data. In linear mode, or whenever the length register holds zero, the step is added with plain modulo-2^ADDR_W arithmetic.

A system with several memory banks instantiates one unit per bank. Instruction decode and the memory itself sit outside this block.

Top module: `circ_agu`

## Requirements
- R1: After reset the address output is 0 and the length register is 0. With length 0 the unit behaves linearly even when circular mode is selected.
- R2: `addrOut` always equals the pointer register. During an access cycle the current pointer is the address, and the pointer changes only at the clock edge that ends the access.
- R3: `ldPtr` writes `ptrIn` into the pointer at the next edge. It wins over an access in the same cycle, so that access's step is discarded.
- R4: In circular mode with len>0, an access sets the pointer to base + ((off + step) mod len). Here k = ceil(log2(len)), base is the pointer with its low k bits cleared, off is those low k bits, and |step| < 2*len.
- R5: With len=6 and offset 0, the steps +0, +5, +2, -3, +6 produce offsets 0, 5, 1, 4, 4 in that order.
- R6: A step of +1 from offset len-1 gives offset 0, and a step of -1 from offset 0 gives offset len-1.
- R7: Steps of 0, +len and -len leave the pointer unchanged in circular mode.
- R8: With `circMode`=0, an access sets the pointer to (pointer + step) mod 2^ADDR_W with no window.
- R9: Without `accValid` or `ldPtr` the pointer holds, whatever value `step` carries.
- R10: `ldLen` writes `lenIn` at the next edge. An access in the same cycle still uses the old length.
- R11: A power-of-two length uses the whole aligned block, so for len=8 offset 7 + 1 gives offset 0.
- R12: With len=1 every circular access leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ldPtr | input | 1 | Load the pointer from ptrIn |
| ptrIn | input | ADDR_W | Pointer load value |
| ldLen | input | 1 | Load the window length from lenIn |
| lenIn | input | ADDR_W | Window length load value |
| circMode | input | 1 | 1 selects circular post-modify, 0 selects linear |
| accValid | input | 1 | Access in this cycle; the pointer is post-modified |
| step | input | ADDR_W+1 | Signed post-modify amount, two's complement |
| addrOut | output | ADDR_W | Memory address (the current pointer) |

## Verification
The main sweep covers every window length from 1 to 12. For each length it starts from every offset in the window and applies every step strictly between -2*len and +2*len. This separates the single and double wrap corrections in both directions, and it shows whether non-power-of-two lengths are handled differently from power-of-two ones. The fixed sequence at length 6 and the unit-step cases at both window edges confirm the ordering behaviour. Linear runs that cross the top and bottom of the address space separate modulo-2^ADDR_W wrap from window wrap. A length-0 run separates the forced linear path from the mode input. Same-cycle collisions of pointer load, length load and access show which input takes effect.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;
  typedef struct packed {
    logic loadPtr;
    logic stepPtr;
    logic useWrap;
  } aguStrobes_t;
endpackage

// File: rtl/circ_agu_ctrl.sv
module circ_agu_ctrl
  import circ_agu_pkg::*;
(
  input  logic        ldPtr,
  input  logic        accValid,
  input  logic        circMode,
  input  logic        lenZero,
  output aguStrobes_t strobes
);
  always_comb begin
    strobes.loadPtr = ldPtr;
    strobes.stepPtr = accValid && !ldPtr;
    strobes.useWrap = circMode && !lenZero;
  end
endmodule

// File: rtl/circ_agu_wrap.sv
module circ_agu_wrap #(
  parameter int ADDR_W = 8,
  parameter int STEP_W = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0]        ptr,
  input  logic [ADDR_W-1:0]        len,
  input  logic signed [STEP_W-1:0] step,
  output logic [ADDR_W-1:0]        nextPtr,
  output logic [ADDR_W-1:0]        winMask
);
  localparam int SUM_W = ((ADDR_W > STEP_W) ? ADDR_W : STEP_W) + 3;

  logic [ADDR_W-1:0] lenM1;
  logic [ADDR_W-1:0] offBits;
  logic [ADDR_W-1:0] baseBits;
  logic signed [SUM_W-1:0] lenS, sum, fix1, fix2;

  assign lenM1 = len - 1'b1;

  // window mask: every bit at or below the top set bit of len-1
  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign winMask[i] = |(lenM1 >> i);
  end

  always_comb begin
    offBits  = ptr & winMask;
    baseBits = ptr & ~winMask;
    lenS     = $signed({{(SUM_W-ADDR_W){1'b0}}, len});
    sum      = $signed({{(SUM_W-ADDR_W){1'b0}}, offBits}) + SUM_W'(step);
    if (sum < 0) begin
      fix1 = sum + lenS;
      fix2 = (fix1 < 0) ? fix1 + lenS : fix1;
    end else begin
      fix1 = (sum >= lenS) ? sum - lenS : sum;
      fix2 = (fix1 >= lenS) ? fix1 - lenS : fix1;
    end
    nextPtr = baseBits | (ADDR_W'(fix2) & winMask);
  end
endmodule

// File: rtl/circ_agu_dp.sv
module circ_agu_dp
  import circ_agu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STEP_W = ADDR_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  aguStrobes_t              strobes,
  input  logic [ADDR_W-1:0]        ptrIn,
  input  logic                     ldLen,
  input  logic [ADDR_W-1:0]        lenIn,
  input  logic signed [STEP_W-1:0] step,
  output logic [ADDR_W-1:0]        ptrQ,
  output logic [ADDR_W-1:0]        lenQ
);
  logic [ADDR_W-1:0] circNext;
  logic [ADDR_W-1:0] linNext;
  logic [ADDR_W-1:0] winMask;
  logic [ADDR_W-1:0] ptrD;

  circ_agu_wrap #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_wrap (
    .ptr     (ptrQ),
    .len     (lenQ),
    .step    (step),
    .nextPtr (circNext),
    .winMask (winMask)
  );

  assign linNext = ptrQ + ADDR_W'(step);

  always_comb begin
    ptrD = ptrQ;
    if (strobes.loadPtr)      ptrD = ptrIn;
    else if (strobes.stepPtr) ptrD = strobes.useWrap ? circNext : linNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
      lenQ <= '0;
    end else begin
      ptrQ <= ptrD;
      if (ldLen) lenQ <= lenIn;
    end
  end

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadPtr && !strobes.stepPtr) |=> $stable(ptrQ));

  // R3
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPtr |=> (ptrQ == $past(ptrIn)));

  // R10
  len_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldLen |=> (lenQ == $past(lenIn)));

  // R4
  win_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepPtr && strobes.useWrap && !ldLen)
      |=> ((ptrQ & ~winMask) == ($past(ptrQ) & ~winMask)));

  // R4
  win_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepPtr && strobes.useWrap && !ldLen && ((ptrQ & winMask) < lenQ))
      |=> ((ptrQ & winMask) < lenQ));

  // R8
  lin_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepPtr && !strobes.useWrap)
      |=> (ptrQ == ADDR_W'($past(ptrQ) + ADDR_W'($past(step)))));
endmodule

// File: rtl/circ_agu.sv
module circ_agu
  import circ_agu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STEP_W = ADDR_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ldPtr,
  input  logic [ADDR_W-1:0]        ptrIn,
  input  logic                     ldLen,
  input  logic [ADDR_W-1:0]        lenIn,
  input  logic                     circMode,
  input  logic                     accValid,
  input  logic signed [STEP_W-1:0] step,
  output logic [ADDR_W-1:0]        addrOut
);
  aguStrobes_t       strobes;
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] lenQ;

  circ_agu_ctrl u_ctrl (
    .ldPtr    (ldPtr),
    .accValid (accValid),
    .circMode (circMode),
    .lenZero  (lenQ == '0),
    .strobes  (strobes)
  );

  circ_agu_dp #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .ptrIn   (ptrIn),
    .ldLen   (ldLen),
    .lenIn   (lenIn),
    .step    (step),
    .ptrQ    (ptrQ),
    .lenQ    (lenQ)
  );

  assign addrOut = ptrQ;

  // R1
  len_zero_lin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lenQ == '0) |-> !strobes.useWrap);
endmodule

// File: tb/circ_agu_bench.sv
module circ_agu_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldPtr = 1'b0, ldLen = 1'b0, circMode = 1'b1, accValid = 1'b0;
  logic [7:0] ptrIn = '0, lenIn = '0;
  logic signed [8:0] step = '0;
  logic [7:0] addrOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  circ_agu u_circ_agu (
    .clk(clk), .rstN(rstN), .ldPtr(ldPtr), .ptrIn(ptrIn), .ldLen(ldLen),
    .lenIn(lenIn), .circMode(circMode), .accValid(accValid), .step(step),
    .addrOut(addrOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic setLen(input int v);
    @(negedge clk); ldLen = 1'b1; lenIn = 8'(v);
    @(negedge clk); ldLen = 1'b0;
  endtask

  task automatic loadP(input int v);
    @(negedge clk); ldPtr = 1'b1; ptrIn = 8'(v);
    @(negedge clk); ldPtr = 1'b0;
  endtask

  task automatic access(input int s);
    @(negedge clk); accValid = 1'b1; step = 9'(s);
    @(negedge clk); accValid = 1'b0; step = 9'sd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset address", addrOut, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 address after reset release", addrOut, 8'h00);
    // R1: length 0 after reset forces linear even in circular mode
    loadP(8'h25);
    chk("R3 pointer load", addrOut, 8'h25);
    access(3);
    chk("R1 length zero linear", addrOut, 8'h28);

    // R5 fixed sequence, len 6, base 0x40
    setLen(6);
    loadP(8'h40);
    access(0);  chk("R5 step +0", addrOut, 8'h40);
    access(5);  chk("R5 step +5", addrOut, 8'h45);
    access(2);  chk("R5 step +2", addrOut, 8'h41);
    access(-3); chk("R5 step -3", addrOut, 8'h44);
    access(6);  chk("R5 step +6", addrOut, 8'h44);

    // R6 unit steps at window edges, with R2 address during access
    loadP(8'h45);
    @(negedge clk); accValid = 1'b1; step = 9'sd1;
    #2 chk("R2 address during access", addrOut, 8'h45);
    @(negedge clk); accValid = 1'b0; step = 9'sd0;
    chk("R6 +1 from top offset", addrOut, 8'h40);
    access(-1); chk("R6 -1 from offset 0", addrOut, 8'h45);

    // R7 step 0, +len, -len
    loadP(8'h43);
    access(6);  chk("R7 step +len", addrOut, 8'h43);
    access(-6); chk("R7 step -len", addrOut, 8'h43);
    access(0);  chk("R7 step 0", addrOut, 8'h43);

    // R9 step ignored without access
    @(negedge clk); step = 9'sd3;
    @(negedge clk); step = 9'sd0;
    chk("R9 hold without access", addrOut, 8'h43);

    // R3 load wins over same-cycle access
    @(negedge clk); ldPtr = 1'b1; ptrIn = 8'h12; accValid = 1'b1; step = 9'sd1;
    @(negedge clk); ldPtr = 1'b0; accValid = 1'b0; step = 9'sd0;
    chk("R3 load beats access", addrOut, 8'h12);

    // R8 linear mode
    circMode = 1'b0;
    loadP(8'h45); access(1);  chk("R8 linear no window", addrOut, 8'h46);
    loadP(8'hFE); access(5);  chk("R8 linear top wrap", addrOut, 8'h03);
    loadP(8'h02); access(-5); chk("R8 linear bottom wrap", addrOut, 8'hFD);
    circMode = 1'b1;

    // R10 length load with same-cycle access uses old length
    loadP(8'h45);
    @(negedge clk); ldLen = 1'b1; lenIn = 8'd8; accValid = 1'b1; step = 9'sd1;
    @(negedge clk); ldLen = 1'b0; accValid = 1'b0; step = 9'sd0;
    chk("R10 old length in load cycle", addrOut, 8'h40);
    access(5); chk("R10 new length used", addrOut, 8'h45);
    // R11 power-of-two length uses full block
    loadP(8'h47); access(1); chk("R11 len 8 wrap", addrOut, 8'h40);
    access(-1); chk("R11 len 8 back", addrOut, 8'h47);

    // R12 length one
    setLen(1);
    loadP(8'h30); access(5); chk("R12 len 1 holds", addrOut, 8'h30);

    // R4 sweep: all lengths 1..12, all offsets, all steps |s|<2len
    for (int len = 1; len <= 12; len++) begin
      int k, mask, base;
      k = 0;
      while ((1 << k) < len) k++;
      mask = (1 << k) - 1;
      base = ((len * 53) & 255) & ~mask;
      setLen(len);
      for (int o = 0; o < len; o++) begin
        for (int s = -(2 * len - 1); s <= 2 * len - 1; s++) begin
          int exp;
          exp = base + ((((o + s) % len) + len) % len);
          loadP(base + o);
          access(s);
          chk("R4 circular sweep", addrOut, 8'(exp));
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule